// File: doc/BRIEF.md
# Largest-Pending-First Statistics Counter Bank

The block keeps a bank of event counters whose full 64-bit totals live in a slow backing store. The store allows only one read-modify-write every `SLOT_DIV` clock slots. Each counter also has a short, fast front counter. Every slot, several increment lanes can bump front counters, since one classified packet may touch several statistics at once. At each backing-store opportunity, the block picks the front counter holding the most pending events. It adds that value into the counter's 64-bit backing entry and zeroes the front counter.

Draining the most-loaded counter first, rather than sweeping in a fixed rotation, bounds how far any front counter can climb. The bound grows only slowly with the number of counters and with `SLOT_DIV`. As a result, a few bits of fast storage per counter are enough. A read port returns the true total of a counter, which is its backing part plus its pending front part. A report port shows each backing-store transaction as it is issued. A sticky error flag records any front counter that would have wrapped.

Top module: `lcf_stat_counters`

## Requirements
- R1: While reset is asserted, every front counter and backing entry is zero, and `rd_vld`, `flush_vld`, `flush_idx`, `flush_amt`, `rd_data` and `ovf_err` are all zero.
- R2: In each cycle, every lane with its `inc_vld` bit set adds one to the front counter named by its 4-bit field of `inc_idx`, where lane k uses bits [4k+3:4k]. Two lanes naming the same counter add two.
- R3: Backing-store opportunities fall on the cycles with index 19, 39, 59 and so on, counting the first cycle after reset as index 0. At each opportunity, the front counter with the largest value is selected, and on a tie the lowest index wins. If every front counter is zero, no transaction is issued.
- R4: A transaction adds the selected front value into that counter's backing entry and clears the front counter. Increments to the same counter in the same cycle are kept in the cleared front counter.
- R5: After the edge that performs a transaction, `flush_vld` is high for exactly one cycle, with `flush_idx` and `flush_amt` giving the counter and the amount moved. At every other time `flush_vld` is low.
- R6: A cycle with `rd_en` high makes `rd_vld` high in the next cycle. In that cycle, `rd_data` equals the backing entry plus the front value of counter `rd_idx`, both as they stood before the edge that sampled the request.
- R7: A front counter whose sum would exceed 2^NARROW_W−1 holds at that maximum and sets the sticky `ovf_err`. Under the default sizes, no increment pattern of the bench ever sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously at chip level |
| inc_vld | input | NUM_LANES | Per-lane increment request |
| inc_idx | input | NUM_LANES*IDX_W | Per-lane counter index, lane k in field k |
| rd_en | input | 1 | Read request |
| rd_idx | input | IDX_W | Counter to read |
| rd_vld | output | 1 | Read result valid |
| rd_data | output | WIDE_W | Full counter total |
| flush_vld | output | 1 | Backing-store transaction issued on the previous edge |
| flush_idx | output | IDX_W | Counter drained by that transaction |
| flush_amt | output | NARROW_W | Amount moved into the backing entry |
| ovf_err | output | 1 | Sticky front-counter saturation flag |

## Verification
Two functions can fall in the same cycle: a drain of the selected front counter, and an increment of that same counter. A directed sequence places an increment on the largest counter at exactly the opportunity cycle. A read afterwards must show the drained amount in the backing part plus one pending event. Long random and spread traffic then hits the same collision many times. On every cycle, a behavioural model of totals and pending counts checks the report and read ports.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

  localparam int unsigned LCF_WIDE_W_DEF = 64;

  function automatic int unsigned lcf_bits_for(input int unsigned n);
    int unsigned r;
    r = 1;
    while ((1 << r) < n) r++;
    return r;
  endfunction

endpackage

// File: rtl/lcf_slot_timer.sv
module lcf_slot_timer #(
  parameter int unsigned SLOT_DIV = 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_open
);
  localparam int unsigned CNT_W = lcf_pkg::lcf_bits_for(SLOT_DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slot_open = (cnt_q == LAST);
endmodule

// File: rtl/lcf_front_bank.sv
module lcf_front_bank #(
  parameter int unsigned NUM_CTR   = 16,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned IDX_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LANES-1:0]          inc_vld,
  input  logic [NUM_LANES*IDX_W-1:0]    inc_idx,
  input  logic                          clr_en,
  input  logic [IDX_W-1:0]              clr_idx,
  output logic [NUM_CTR*NARROW_W-1:0]   front_flat,
  output logic                          sat_err
);
  localparam int unsigned HIT_W = lcf_pkg::lcf_bits_for(NUM_LANES + 1);
  localparam int unsigned SUM_W = NARROW_W + HIT_W;
  localparam logic [SUM_W-1:0] TOP = {{HIT_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [NUM_CTR-1:0] sat_vec;
  logic               sat_q, sat_d;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    logic [HIT_W-1:0]    hits;
    logic                clr_hit;
    logic [NARROW_W-1:0] base_v, cur_q, nxt_d;
    logic [SUM_W-1:0]    sum_v;
    logic                ce;

    always_comb begin
      hits = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
        if (inc_vld[l] && (inc_idx[l*IDX_W +: IDX_W] == IDX_W'(c)))
          hits = hits + HIT_W'(1);
      end
      clr_hit = clr_en && (clr_idx == IDX_W'(c));
      base_v  = clr_hit ? '0 : cur_q;
      sum_v   = {{HIT_W{1'b0}}, base_v} + {{NARROW_W{1'b0}}, hits};
      sat_vec[c] = (sum_v > TOP);
      nxt_d   = sat_vec[c] ? {NARROW_W{1'b1}} : sum_v[NARROW_W-1:0];
      ce      = clr_hit || (hits != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cur_q <= '0;
      else if (ce) cur_q <= nxt_d;
    end

    assign front_flat[c*NARROW_W +: NARROW_W] = cur_q;
  end

  always_comb sat_d = sat_q | (|sat_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_q <= 1'b0;
    else        sat_q <= sat_d;
  end

  assign sat_err = sat_q;
endmodule

// File: rtl/lcf_max_pick.sv
module lcf_max_pick #(
  parameter int unsigned NUM_CTR  = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned IDX_W    = 4
) (
  input  logic [NUM_CTR*NARROW_W-1:0] front_flat,
  output logic [NARROW_W-1:0]         best_val,
  output logic [IDX_W-1:0]            best_idx,
  output logic                        best_nz
);
  always_comb begin
    best_val = front_flat[NARROW_W-1:0];
    best_idx = '0;
    for (int c = 1; c < NUM_CTR; c++) begin
      if (front_flat[c*NARROW_W +: NARROW_W] > best_val) begin
        best_val = front_flat[c*NARROW_W +: NARROW_W];
        best_idx = IDX_W'(c);
      end
    end
    best_nz = (best_val != '0);
  end
endmodule

// File: rtl/lcf_wide_store.sv
module lcf_wide_store #(
  parameter int unsigned NUM_CTR  = 16,
  parameter int unsigned WIDE_W   = 64,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned IDX_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                add_en,
  input  logic [IDX_W-1:0]    add_idx,
  input  logic [NARROW_W-1:0] add_amt,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [WIDE_W-1:0]   rd_word
);
  logic [WIDE_W-1:0] mem_q [NUM_CTR];
  logic [WIDE_W-1:0] add_sum;

  always_comb begin
    add_sum = mem_q[add_idx] + {{(WIDE_W-NARROW_W){1'b0}}, add_amt};
    rd_word = mem_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CTR; c++) mem_q[c] <= '0;
    end else if (add_en) begin
      mem_q[add_idx] <= add_sum;
    end
  end
endmodule

// File: rtl/lcf_stat_counters.sv
module lcf_stat_counters #(
  parameter int unsigned NUM_CTR   = 16,
  parameter int unsigned NARROW_W  = 8,
  parameter int unsigned WIDE_W    = lcf_pkg::LCF_WIDE_W_DEF,
  parameter int unsigned SLOT_DIV  = 20,
  parameter int unsigned NUM_LANES = 2,
  localparam int unsigned IDX_W    = lcf_pkg::lcf_bits_for(NUM_CTR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LANES-1:0]       inc_vld,
  input  logic [NUM_LANES*IDX_W-1:0] inc_idx,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic                       rd_vld,
  output logic [WIDE_W-1:0]          rd_data,
  output logic                       flush_vld,
  output logic [IDX_W-1:0]           flush_idx,
  output logic [NARROW_W-1:0]        flush_amt,
  output logic                       ovf_err
);
  logic [NUM_CTR*NARROW_W-1:0] narrow_flat;
  logic                        slot_open;
  logic [NARROW_W-1:0]         best_val;
  logic [IDX_W-1:0]            best_idx;
  logic                        best_nz;
  logic                        drain_fire;
  logic [WIDE_W-1:0]           wide_word;
  logic [NARROW_W-1:0]         rd_front;
  logic [WIDE_W-1:0]           rd_sum;

  logic                rd_vld_q, fl_vld_q;
  logic [WIDE_W-1:0]   rd_data_q, rd_data_d;
  logic [IDX_W-1:0]    fl_idx_q;
  logic [NARROW_W-1:0] fl_amt_q;

  lcf_slot_timer #(.SLOT_DIV(SLOT_DIV)) timer_i (
    .clk(clk), .rst_n(rst_n), .slot_open(slot_open)
  );

  lcf_max_pick #(.NUM_CTR(NUM_CTR), .NARROW_W(NARROW_W), .IDX_W(IDX_W)) pick_i (
    .front_flat(narrow_flat), .best_val(best_val), .best_idx(best_idx), .best_nz(best_nz)
  );

  assign drain_fire = slot_open && best_nz;

  lcf_front_bank #(
    .NUM_CTR(NUM_CTR), .NARROW_W(NARROW_W), .NUM_LANES(NUM_LANES), .IDX_W(IDX_W)
  ) front_i (
    .clk(clk), .rst_n(rst_n), .inc_vld(inc_vld), .inc_idx(inc_idx),
    .clr_en(drain_fire), .clr_idx(best_idx),
    .front_flat(narrow_flat), .sat_err(ovf_err)
  );

  lcf_wide_store #(
    .NUM_CTR(NUM_CTR), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .IDX_W(IDX_W)
  ) wide_i (
    .clk(clk), .rst_n(rst_n), .add_en(drain_fire), .add_idx(best_idx),
    .add_amt(best_val), .rd_idx(rd_idx), .rd_word(wide_word)
  );

  always_comb begin
    rd_front = '0;
    for (int c = 0; c < NUM_CTR; c++) begin
      if (rd_idx == IDX_W'(c)) rd_front = narrow_flat[c*NARROW_W +: NARROW_W];
    end
    rd_sum    = wide_word + {{(WIDE_W-NARROW_W){1'b0}}, rd_front};
    rd_data_d = rd_en ? rd_sum : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      rd_data_q <= '0;
      fl_vld_q  <= 1'b0;
      fl_idx_q  <= '0;
      fl_amt_q  <= '0;
    end else begin
      rd_vld_q  <= rd_en;
      rd_data_q <= rd_data_d;
      fl_vld_q  <= drain_fire;
      if (drain_fire) begin
        fl_idx_q <= best_idx;
        fl_amt_q <= best_val;
      end
    end
  end

  assign rd_vld    = rd_vld_q;
  assign rd_data   = rd_data_q;
  assign flush_vld = fl_vld_q;
  assign flush_idx = fl_idx_q;
  assign flush_amt = fl_amt_q;
endmodule

// File: rtl/lcf_stat_counters_chk.sv
module lcf_stat_counters_chk #(
  parameter int unsigned NUM_CTR  = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned SLOT_DIV = 20,
  parameter int unsigned IDX_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rd_en,
  input logic                        rd_vld,
  input logic                        flush_vld,
  input logic [IDX_W-1:0]            flush_idx,
  input logic [NARROW_W-1:0]         flush_amt,
  input logic                        ovf_err,
  input logic [NUM_CTR*NARROW_W-1:0] narrow_flat
);
  localparam int unsigned GAP_W = lcf_pkg::lcf_bits_for(SLOT_DIV + 1);

  logic [GAP_W-1:0]            gap_q;
  logic [NUM_CTR*NARROW_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= narrow_flat;
      if (flush_vld)                     gap_q <= '0;
      else if (gap_q != GAP_W'(SLOT_DIV)) gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R6: read result appears exactly one cycle after the request
  p_rd_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld) else $error("read result missing");
  p_rd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_vld) else $error("spurious read result");

  // R3: drains are never closer together than one backing-store period
  p_drain_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |-> (gap_q >= GAP_W'(SLOT_DIV - 1))) else $error("drain too early");

  // R3: nothing is reported for an empty counter
  p_drain_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_vld |-> (flush_amt != '0)) else $error("zero drain reported");

  // R7: front counters never saturate under the traffic applied
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_err) else $error("front counter saturated");

  // R3/R5: drained amount is the pre-edge largest front value
  always_ff @(posedge clk) begin
    if (rst_n && flush_vld) begin
      p_drain_amt_r5: assert (flush_amt == prev_q[flush_idx*NARROW_W +: NARROW_W])
        else $error("drain amount mismatch");
      for (int c = 0; c < NUM_CTR; c++) begin
        p_drain_largest_r3: assert (prev_q[c*NARROW_W +: NARROW_W] <= flush_amt)
          else $error("drained counter was not the largest");
      end
    end
  end
endmodule

bind lcf_stat_counters lcf_stat_counters_chk #(
  .NUM_CTR(NUM_CTR), .NARROW_W(NARROW_W), .SLOT_DIV(SLOT_DIV), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_vld(rd_vld),
  .flush_vld(flush_vld), .flush_idx(flush_idx), .flush_amt(flush_amt),
  .ovf_err(ovf_err), .narrow_flat(narrow_flat)
);

// File: tb/lcf_stat_counters_tb.sv
module lcf_stat_counters_tb_top;
  localparam int N    = 16;
  localparam int NW   = 8;
  localparam int SD   = 20;
  localparam int L    = 2;
  localparam int IW   = 4;
  localparam int NMAX = (1 << NW) - 1;

  logic          clk, rst_n;
  logic [L-1:0]  inc_vld;
  logic [L*IW-1:0] inc_idx;
  logic          rd_en;
  logic [IW-1:0] rd_idx;
  logic          rd_vld, flush_vld, ovf_err;
  logic [63:0]   rd_data;
  logic [IW-1:0] flush_idx;
  logic [NW-1:0] flush_amt;

  lcf_stat_counters #(.NUM_CTR(N), .NARROW_W(NW), .WIDE_W(64), .SLOT_DIV(SD), .NUM_LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .inc_vld(inc_vld), .inc_idx(inc_idx),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_data(rd_data),
    .flush_vld(flush_vld), .flush_idx(flush_idx), .flush_amt(flush_amt), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cyc = 0;

  int              m_front [N];
  longint unsigned m_wide [N];
  int              m_slot;
  bit              e_rv, e_fv, e_ovf;
  longint unsigned e_rd;
  int              e_fi, e_fa;

  task automatic check(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N; c++) begin m_front[c] = 0; m_wide[c] = 0; end
      m_slot = 0; e_rv = 0; e_fv = 0; e_ovf = 0; e_rd = 0; e_fi = 0; e_fa = 0; cyc = 0;
    end else begin
      int best, bi;
      cyc++;
      e_rv = rd_en;
      if (rd_en) e_rd = m_wide[rd_idx] + longint'(m_front[rd_idx]);
      e_fv = 0;
      if (m_slot == SD - 1) begin
        best = 0; bi = 0;
        for (int c = 0; c < N; c++) if (m_front[c] > best) begin best = m_front[c]; bi = c; end
        if (best > 0) begin
          e_fv = 1; e_fi = bi; e_fa = best;
          m_wide[bi] += longint'(best);
          m_front[bi] = 0;
        end
      end
      for (int l = 0; l < L; l++) begin
        if (inc_vld[l]) begin
          int k;
          k = int'(inc_idx[l*IW +: IW]);
          m_front[k]++;
          if (m_front[k] > NMAX) begin m_front[k] = NMAX; e_ovf = 1; end
        end
      end
      m_slot = (m_slot == SD - 1) ? 0 : m_slot + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cyc > 0 && !done) begin
      check(flush_vld == e_fv, "R5 flush_vld", flush_vld, e_fv);
      if (e_fv) begin
        check(flush_idx == e_fi[IW-1:0], "R3 flush_idx", flush_idx, e_fi);
        check(flush_amt == e_fa[NW-1:0], "R4 flush_amt", flush_amt, e_fa);
      end
      check(rd_vld == e_rv, "R6 rd_vld", rd_vld, e_rv);
      if (e_rv) check(rd_data == e_rd, "R6 rd_data", rd_data, e_rd);
      check(ovf_err == e_ovf, "R7 ovf_err", ovf_err, e_ovf);
    end
  end

  task automatic step(input bit v0, input int i0, input bit v1, input int i1, input bit re, input int ri);
    inc_vld = {v1, v0};
    inc_idx = {i1[IW-1:0], i0[IW-1:0]};
    rd_en   = re;
    rd_idx  = ri[IW-1:0];
    @(negedge clk);
  endtask

  task automatic idle_to(input int edge_n);
    while (cyc < edge_n - 1) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; inc_vld = '0; inc_idx = '0; rd_en = 0; rd_idx = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rd_vld && !flush_vld && !ovf_err, "R1 flags in reset", {rd_vld, flush_vld, ovf_err}, 0);
    check(rd_data == 0 && flush_amt == 0 && flush_idx == 0, "R1 data in reset", rd_data, 0);
    rst_n = 1;
    // R2: lane sums, same-index lanes add two
    step(1, 3, 1, 3, 0, 0);
    step(1, 3, 1, 3, 0, 0);
    step(1, 7, 1, 3, 0, 0);
    step(0, 0, 0, 0, 1, 3);
    check(rd_data == 5, "R2 counter 3 total", rd_data, 5);
    step(0, 0, 0, 0, 1, 7);
    check(rd_data == 1, "R2 counter 7 total", rd_data, 1);
    // R3/R4: opportunity at edge 20 with a colliding increment to the drained counter
    idle_to(20);
    step(1, 3, 0, 0, 0, 0);
    check(flush_vld && flush_idx == 3 && flush_amt == 5, "R3 first drain picks largest", flush_amt, 5);
    step(0, 0, 0, 0, 1, 3);
    check(rd_data == 6, "R4 collision increment kept", rd_data, 6);
    // R3: tie of 1 vs 1 resolves to lowest index
    idle_to(40);
    step(0, 0, 0, 0, 0, 0);
    check(flush_vld && flush_idx == 3 && flush_amt == 1, "R3 tie to lowest index", flush_idx, 3);
    idle_to(60);
    step(0, 0, 0, 0, 0, 0);
    check(flush_vld && flush_idx == 7, "R3 remaining counter drained", flush_idx, 7);
    idle_to(80);
    step(0, 0, 0, 0, 0, 0);
    check(!flush_vld, "R3 no drain when all empty", flush_vld, 0);
    // spread traffic across all counters (R7 bound)
    for (int k = 0; k < 800; k++) step(1, k % N, 1, (k + 8) % N, (k % 7) == 0, k % N);
    // hammer one counter (R4 collisions every opportunity)
    for (int k = 0; k < 200; k++) step(1, 0, 1, 0, (k % 5) == 0, 0);
    // skewed: keep feeding the counters not drained recently
    for (int k = 0; k < 600; k++) step(1, N - 1 - (k / 40) % N, 1, (k / 20) % N, (k % 9) == 0, k % N);
    // pseudo-random traffic
    for (int k = 0; k < 2000; k++)
      step($urandom % 4 != 0, $urandom % N, $urandom % 3 != 0, $urandom % N, $urandom % 3 == 0, $urandom % N);
    // read every total back
    for (int c = 0; c < N; c++) step(0, 0, 0, 0, 1, c);
    step(0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule